// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a flash memory. It confirms that a program or erase the host has already launched has finished. A start pulse loads three things: the datum the device should end up holding, an address that is valid for the operation, and a cap on the number of polls. For an erase, the expected top bit is 1 and the address lies in a sector being erased.

The poller then issues single-byte reads over a simple request/valid handshake. It compares bit 7 of each returned byte with bit 7 of the expected datum. A mismatch with bit 5 clear means the device is still working, so the poller reads again. A mismatch with bit 5 set means the device reports that it ran past its time limit. Bit 7 can flip in that same read, so the poller rechecks it once more before declaring failure.

Bit 7 settles before the lower bits, so the byte that shows completion cannot be trusted as data. After every pass the poller makes one more read and presents that byte as the verified datum. A poll cap loaded with the start pulse ensures that a device which never answers still produces a fail result.

Top module: `flash_done_poller`

## Requirements
- R1: After reset the block is idle: `rdReq`, `busy`, `done`, `passed` and `failed` are 0, and `verifiedData` is 0.
- R2: A `start` seen while idle loads `expData`, `pollAddr` and `maxPolls`, and drives `rdReq` in the following cycle. Each read is a one-cycle `rdReq` pulse. The next pulse comes only after `rdValid`. `rdAddr` stays at the loaded address for the whole operation, even if `pollAddr` changes.
- R3: When a polling read returns bit 7 equal to bit 7 of the loaded datum, exactly one further confirming read is made, and then the result is pass.
- R4: When a polling read returns bit 7 unequal to the expected bit and bit 5 equal to 0, the block polls again.
- R5: When a polling read returns bit 7 unequal and bit 5 equal to 1, exactly one recheck read follows. If the recheck's bit 7 matches, a confirming read follows and the result is pass. If it does not match, the result is fail with no further read.
- R6: A polling read whose bit 7 matches counts as completion even when its bit 5 is 1.
- R7: On pass, `verifiedData` equals the byte returned by the confirming read. On fail it is 0.
- R8: The number of polling reads never exceeds the effective cap, which is `maxPolls`, or 1 when `maxPolls` is 0. A mismatching polling read with bit 5 clear that reaches the cap ends the operation with fail.
- R9: `done` is high for exactly one cycle per operation. At that point exactly one of `passed` and `failed` is 1. Both hold until the next accepted `start`, which clears them.
- R10: A `start` pulse while `busy` is 1 has no effect on the address, the expected datum, the read sequence or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (honoured only while idle) |
| expData | input | 8 | Datum expected at the address once finished |
| pollAddr | input | ADDR_W | Address to poll |
| maxPolls | input | CNT_W | Cap on polling reads (0 treated as 1) |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | 8 | Byte returned by the device |
| rdValid | input | 1 | `rdData` is valid this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| passed | output | 1 | Operation finished successfully |
| failed | output | 1 | Operation failed or hit the poll cap |
| verifiedData | output | 8 | Byte from the confirming read |

## Verification
On every cycle, the assertions check the following:
- `rdReq` and `done` are single-cycle pulses.
- `rdAddr` holds steady while busy.
- The poll count stays within the cap.
- A mismatched recheck ends the operation at once.
- Pass and fail are never both set.

Only the bench's scenarios can show whether the right sequence of reads happened. That covers the confirming read after a match, the single recheck after bit 5, and how many reads the cap allows. They also show which byte ends up in `verifiedData` and that a start pulse during an operation leaves everything unchanged.

// File: rtl/poller_pkg.sv
package poller_pkg;

  typedef struct packed {
    logic load;
    logic countPoll;
    logic takeFinal;
    logic setPass;
    logic setFail;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_CHK_REQ,
    S_CHK_WAIT,
    S_CONF_REQ,
    S_CONF_WAIT,
    S_DONE
  } state_t;

endpackage

// File: rtl/poller_dpath.sv
module poller_dpath
  import poller_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [7:0]        expData,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic [7:0]        rdData,
  output logic              bitMatch,
  output logic              timeoutBit,
  output logic              atLimit,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              passed,
  output logic              failed,
  output logic [7:0]        verifiedData
);

  localparam int WIDE_W = CNT_W + 1;

  logic              expBit;
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  limitReg;
  logic [CNT_W-1:0]  pollCount;
  logic              passReg;
  logic              failReg;
  logic [7:0]        dataReg;
  logic [WIDE_W-1:0] nextCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expBit    <= 1'b0;
      addrReg   <= '0;
      limitReg  <= CNT_W'(1);
      pollCount <= '0;
      passReg   <= 1'b0;
      failReg   <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (strobe.load) begin
        expBit    <= expData[7];
        addrReg   <= pollAddr;
        limitReg  <= (maxPolls == '0) ? CNT_W'(1) : maxPolls;
        pollCount <= '0;
        passReg   <= 1'b0;
        failReg   <= 1'b0;
        dataReg   <= '0;
      end else begin
        if (strobe.countPoll) pollCount <= pollCount + CNT_W'(1);
        if (strobe.takeFinal) dataReg   <= rdData;
        if (strobe.setPass)   passReg   <= 1'b1;
        if (strobe.setFail)   failReg   <= 1'b1;
      end
    end
  end

  assign nextCount  = {1'b0, pollCount} + WIDE_W'(1);
  assign bitMatch   = (rdData[7] == expBit);
  assign timeoutBit = rdData[5];
  assign atLimit    = (nextCount >= {1'b0, limitReg});

  assign rdAddr       = addrReg;
  assign passed       = passReg;
  assign failed       = failReg;
  assign verifiedData = dataReg;

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    pollCount <= limitReg);

  p_single_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(passReg && failReg));

endmodule

// File: rtl/poller_ctrl.sv
module poller_ctrl
  import poller_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    rdValid,
  input  logic    bitMatch,
  input  logic    timeoutBit,
  input  logic    atLimit,
  output strobe_t strobe,
  output logic    rdReq,
  output logic    busy,
  output logic    done
);

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = S_POLL_REQ;
        end
      end
      S_POLL_REQ: nextState = S_POLL_WAIT;
      S_POLL_WAIT: begin
        if (rdValid) begin
          strobe.countPoll = 1'b1;
          if (bitMatch) begin
            nextState = S_CONF_REQ;
          end else if (timeoutBit) begin
            nextState = S_CHK_REQ;
          end else if (atLimit) begin
            strobe.setFail = 1'b1;
            nextState      = S_DONE;
          end else begin
            nextState = S_POLL_REQ;
          end
        end
      end
      S_CHK_REQ: nextState = S_CHK_WAIT;
      S_CHK_WAIT: begin
        if (rdValid) begin
          if (bitMatch) begin
            nextState = S_CONF_REQ;
          end else begin
            strobe.setFail = 1'b1;
            nextState      = S_DONE;
          end
        end
      end
      S_CONF_REQ: nextState = S_CONF_WAIT;
      S_CONF_WAIT: begin
        if (rdValid) begin
          strobe.takeFinal = 1'b1;
          strobe.setPass   = 1'b1;
          nextState        = S_DONE;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign rdReq = (state == S_POLL_REQ) || (state == S_CHK_REQ) || (state == S_CONF_REQ);
  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_recheck_miss_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK_WAIT && rdValid && !bitMatch) |=> (done && !rdReq));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import poller_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        expData,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              busy,
  output logic              done,
  output logic              passed,
  output logic              failed,
  output logic [7:0]        verifiedData
);

  strobe_t strobe;
  logic    bitMatch;
  logic    timeoutBit;
  logic    atLimit;

  poller_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rdValid    (rdValid),
    .bitMatch   (bitMatch),
    .timeoutBit (timeoutBit),
    .atLimit    (atLimit),
    .strobe     (strobe),
    .rdReq      (rdReq),
    .busy       (busy),
    .done       (done)
  );

  poller_dpath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .expData      (expData),
    .pollAddr     (pollAddr),
    .maxPolls     (maxPolls),
    .rdData       (rdData),
    .bitMatch     (bitMatch),
    .timeoutBit   (timeoutBit),
    .atLimit      (atLimit),
    .rdAddr       (rdAddr),
    .passed       (passed),
    .failed       (failed),
    .verifiedData (verifiedData)
  );

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rdAddr));

  p_done_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (passed != failed));

endmodule

// File: tb/flash_done_poller_test.sv
`timescale 1ns/1ps
module flash_done_poller_test;

  localparam int AW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    expData = '0;
  logic [AW-1:0] pollAddr = '0;
  logic [CW-1:0] maxPolls = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic [7:0]    rdData = '0;
  logic          rdValid = 1'b0;
  logic          busy, done, passed, failed;
  logic [7:0]    verifiedData;

  int checks = 0;
  int failures = 0;
  int scExp = 0, scN = 0, scKind = 0;
  int readIdx = 0, readBase = 0;
  int addrErrs = 0;
  logic [AW-1:0] curAddr = '0;
  logic          v1 = 1'b0;
  logic [7:0]    d1 = '0;

  flash_done_poller #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .expData(expData),
    .pollAddr(pollAddr), .maxPolls(maxPolls), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done),
    .passed(passed), .failed(failed), .verifiedData(verifiedData)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] confirmByte();
    logic [7:0] t = 8'(8'h2B + scN * 7 + scKind * 3);
    return {scExp[0], t[6:0]};
  endfunction

  function automatic logic [7:0] respByte(int i);
    logic eb = scExp[0];
    if (i < scN) return {~eb, i[0], 1'b0, 5'(i + 3)};
    if (i == scN) begin
      case (scKind)
        0: return {eb, 2'b00, 5'h11};
        1: return {eb, 2'b11, 5'h0C};
        default: return {~eb, 2'b01, 5'h07};
      endcase
    end
    if (scKind >= 2 && i == scN + 1)
      return (scKind == 2) ? {eb, 2'b10, 5'h09} : {~eb, 2'b11, 5'h0A};
    return confirmByte();
  endfunction

  // device model: data returned two cycles after each request
  always @(posedge clk) begin
    if (rdReq) begin
      d1 <= respByte(readIdx - readBase);
      readIdx <= readIdx + 1;
      if (rdAddr !== curAddr) addrErrs <= addrErrs + 1;
    end
    v1      <= rdReq;
    rdValid <= v1;
    rdData  <= d1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic runOne(input int e, input int n, input int kind, input int lim);
    int eff, expReads, errBase;
    bit expPass, seen;
    logic [7:0] expVd;
    scExp = e; scN = n; scKind = kind;
    readBase = readIdx;
    errBase = addrErrs;
    eff = (lim == 0) ? 1 : lim;
    if (n >= eff) begin expPass = 0; expReads = eff; end
    else if (kind < 2) begin expPass = 1; expReads = n + 2; end
    else if (kind == 2) begin expPass = 1; expReads = n + 3; end
    else begin expPass = 0; expReads = n + 2; end
    expVd = expPass ? confirmByte() : 8'h00;
    curAddr = AW'(16'hA000 + n * 16 + kind + lim * 256 + e * 4096);
    @(negedge clk);
    expData = {e[0], 7'h15}; pollAddr = curAddr; maxPolls = CW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rdReq === 1'b1, "R2", "first request after start", int'(rdReq), 1);
    pollAddr = ~curAddr; expData = ~expData;
    waitDone(seen);
    chk(seen, "R9", "done seen", int'(seen), 1);
    chk(passed === expPass, expPass ? "R3" : "R5", "passed", int'(passed), int'(expPass));
    chk(failed === !expPass, (n >= eff) ? "R8" : "R5", "failed", int'(failed), int'(!expPass));
    chk(verifiedData === expVd, "R7", "verifiedData", int'(verifiedData), int'(expVd));
    chk(readIdx - readBase == expReads, (kind == 1) ? "R6" : "R4", "read count",
        readIdx - readBase, expReads);
    chk(addrErrs == errBase, "R2", "address errors", addrErrs - errBase, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done width", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rdReq && !busy && !done, "R1", "idle controls", int'({rdReq, busy, done}), 0);
    chk(!passed && !failed && verifiedData == 8'h00, "R1", "idle results",
        int'({passed, failed, verifiedData}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int e = 0; e < 2; e++)
      for (int n = 0; n < 5; n++)
        for (int kind = 0; kind < 4; kind++)
          for (int li = 0; li < 4; li++)
            runOne(e, n, kind, (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 8);

    // R9 results hold after done
    scExp = 1; scN = 2; scKind = 0;
    readBase = readIdx; curAddr = 16'h1234;
    @(negedge clk);
    expData = 8'hFF; pollAddr = curAddr; maxPolls = 8'd8; start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10 start during busy with other inputs
    repeat (3) @(negedge clk);
    pollAddr = 16'h4321; expData = 8'h00; maxPolls = 8'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone(seen);
    chk(seen && passed === 1'b1 && failed === 1'b0, "R10", "result despite busy start",
        int'(passed), 1);
    chk(readIdx - readBase == 4, "R10", "read count despite busy start", readIdx - readBase, 4);
    chk(addrErrs == 0, "R10", "address kept", addrErrs, 0);
    repeat (5) @(negedge clk);
    chk(passed === 1'b1 && failed === 1'b0 && !busy, "R9", "pass held", int'(passed), 1);
    chk(verifiedData === confirmByte(), "R9", "data held", int'(verifiedData), int'(confirmByte()));
    scExp = 0; scN = 1; scKind = 0; readBase = readIdx;
    pollAddr = curAddr; expData = 8'h00; maxPolls = 8'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(passed === 1'b0 && failed === 1'b0 && verifiedData === 8'h00, "R9", "cleared by start",
        int'({passed, failed}), 0);
    waitDone(seen);
    chk(seen && passed === 1'b1, "R9", "second pass", int'(passed), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule